// File: doc/BRIEF.md
# Streaming Serial Read Engine

This block serves a streaming read command on a serial memory interface. When the upstream decoder has recognised the read opcode, it raises a one-cycle command strobe. The engine then collects two address bytes, the high one first, and checks a single permission input. If the read is allowed, it walks the memory array upward from that address. Each word is fetched through a synchronous read port with one cycle of latency. The word is cut into 8-bit characters, and each character is shifted out in asynchronous serial format.

The stream has no length. It runs until the top address has been sent, or until chip select is deasserted, whichever comes first. The next word is fetched while the current character is still on the line, so characters leave back to back. The serial output enable is high only while a stream is active. When it is low, the line is meant to be high impedance.

Top module: `seq_read_stream`

## Requirements
- R1: After reset, `txOe` is 0, `txData` is 1 and `memRdEn` is 0.
- R2: After `cmdStart`, the next two `byteValid` bytes form the start address, high byte first. The address is the low `ADDR_W` bits of {high, low}, and the first word read and sent is the word at that address.
- R3: Words are read at strictly consecutive increasing addresses. With `WORD_W`=16, each word leaves as two characters, bits 15:8 first.
- R4: Every character is framed as a start bit of 0, then 8 data bits LSB first, then a stop bit of 1. Each bit lasts `BIT_CLKS` clock cycles.
- R5: When `parityEn` is 1 at the second address byte, a 9th bit is inserted before the stop bit, making the count of ones over the data bits and this bit even. The value of `parityEn` is held for the whole stream, so later changes have no effect.
- R6: While words remain, the start bit of each character begins in the cycle directly after the last cycle of the previous stop bit.
- R7: After the top address (all ones) has been sent, `txOe` falls within two cycles of the end of the last stop bit. No further read or character follows, and `cmdStart` is ignored until chip select has been low.
- R8: While `csIn` is 0, `txOe` is 0 in the same cycle and `memRdEn` is 0. A stream cut off this way does not resume when `csIn` returns high.
- R9: If `readAllowed` is 0 at the second address byte, no read is issued, `txOe` stays 0, and the engine ignores commands until chip select has been low.
- R10: `byteValid` without a preceding `cmdStart` is ignored, and a `cmdStart` seen while `csIn` is 0 is ignored.
- R11: At most one array read is outstanding at a time: `memRdEn` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csIn | input | 1 | Chip select, active high |
| cmdStart | input | 1 | One-cycle strobe: streaming read opcode decoded |
| byteValid | input | 1 | `byteIn` holds a received byte |
| byteIn | input | 8 | Received byte |
| readAllowed | input | 1 | Outcome of the protection checks |
| parityEn | input | 1 | Add an even-parity bit to each character |
| memRdEn | output | 1 | Array read request |
| memAddr | output | ADDR_W | Array read address |
| memRdData | input | WORD_W | Array read data, valid one cycle after `memRdEn` |
| txData | output | 1 | Serial data line |
| txOe | output | 1 | Serial output enable (0 means high impedance) |

## Verification
The hardest state to reach is the end of memory. An ending stream shows two behaviours together: the prefetch must stop, and the final characters must still leave gaplessly before the enable drops. The bench reaches it by starting three words below the top address and decoding every character. It then counts array reads and watches the enable while chip select is still high. A second tricky case is parity latching: the parity input is flipped in the middle of a stream and 11-bit frames are still expected.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_STREAM,
    ST_HALT
  } srs_state_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadHi;  // capture high address byte
    logic start;   // capture low byte, begin a stream
    logic run;     // stream in progress with chip select high
  } srs_ctl_t;

  localparam int CHAR_BITS = 8;
endpackage

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     csIn,
  input  logic     cmdStart,
  input  logic     byteValid,
  input  logic     readAllowed,
  input  logic     streamDone,
  output srs_ctl_t ctl,
  output logic     txOe
);
  srs_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else if (!csIn) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:    if (cmdStart) state <= ST_ADDR_HI;
        ST_ADDR_HI: if (byteValid) state <= ST_ADDR_LO;
        ST_ADDR_LO: if (byteValid) state <= readAllowed ? ST_STREAM : ST_HALT;
        ST_STREAM:  if (streamDone) state <= ST_HALT;
        ST_HALT:    state <= ST_HALT;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadHi = csIn && (state == ST_ADDR_HI) && byteValid;
    ctl.start  = csIn && (state == ST_ADDR_LO) && byteValid && readAllowed;
    ctl.run    = csIn && (state == ST_STREAM);
    txOe       = ctl.run;
  end

  AST_DONE_DROPS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    streamDone |=> !txOe); // R7
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |=> !txOe); // R7
  AST_OE_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txOe) |-> $past(readAllowed)); // R9
endmodule

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int WORD_W   = 16,
  parameter int BIT_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  srs_ctl_t          ctl,
  input  logic [7:0]        byteIn,
  input  logic              parityEn,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [WORD_W-1:0] memRdData,
  output logic              txBit,
  output logic              streamDone
);
  localparam int CPW    = WORD_W / CHAR_BITS;
  localparam int CPW_W  = $clog2(CPW + 1);
  localparam int BAUD_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};
  localparam logic [BAUD_W-1:0] BAUD_LAST = BAUD_W'(BIT_CLKS - 1);

  logic [7:0]        addrHi;
  logic [ADDR_W-1:0] addr, startAddr;
  logic              active, parLatched, endReached, inFlight;
  logic [WORD_W-1:0] nextWord, curWord;
  logic              nextValid;
  logic [CPW_W-1:0]  charsLeft;
  logic [10:0]       shiftReg;
  logic [3:0]        bitsLeft;
  logic [BAUD_W-1:0] baudCnt;
  logic              busy;

  logic       charEnd, haveCur, loadChar;
  logic [7:0] charByte;

  assign startAddr  = ADDR_W'({addrHi, byteIn});
  assign memAddr    = addr;
  assign memRdEn    = ctl.run && active && !nextValid && !inFlight && !endReached;
  assign charEnd    = busy && (bitsLeft == 4'd1) && (baudCnt == BAUD_LAST);
  assign haveCur    = (charsLeft != '0);
  assign loadChar   = ctl.run && active && (!busy || charEnd) && (haveCur || nextValid);
  assign charByte   = haveCur ? curWord[WORD_W-1 -: 8] : nextWord[WORD_W-1 -: 8];
  assign streamDone = active && endReached && !nextValid && !haveCur && !busy && !inFlight;
  assign txBit      = busy ? shiftReg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrHi     <= '0;
      addr       <= '0;
      active     <= 1'b0;
      parLatched <= 1'b0;
      endReached <= 1'b0;
      inFlight   <= 1'b0;
      nextWord   <= '0;
      nextValid  <= 1'b0;
      curWord    <= '0;
      charsLeft  <= '0;
      shiftReg   <= '1;
      bitsLeft   <= '0;
      baudCnt    <= '0;
      busy       <= 1'b0;
    end else begin
      if (ctl.loadHi) addrHi <= byteIn;
      if (ctl.start) begin
        active     <= 1'b1;
        addr       <= startAddr;
        parLatched <= parityEn;
        endReached <= 1'b0;
        inFlight   <= 1'b0;
        nextValid  <= 1'b0;
        charsLeft  <= '0;
        busy       <= 1'b0;
      end else if (!ctl.run) begin
        active    <= 1'b0;
        inFlight  <= 1'b0;
        nextValid <= 1'b0;
        charsLeft <= '0;
        busy      <= 1'b0;
      end else begin
        inFlight <= memRdEn;
        if (inFlight) begin
          nextWord  <= memRdData;
          nextValid <= 1'b1;
          if (addr == ADDR_MAX) endReached <= 1'b1;
          else addr <= addr + ADDR_W'(1);
        end
        if (loadChar) begin
          if (haveCur) begin
            curWord   <= curWord << CHAR_BITS;
            charsLeft <= charsLeft - CPW_W'(1);
          end else begin
            curWord   <= nextWord << CHAR_BITS;
            charsLeft <= CPW_W'(CPW - 1);
            nextValid <= 1'b0;
          end
          shiftReg <= parLatched ? {1'b1, ^charByte, charByte, 1'b0}
                                 : {2'b11, charByte, 1'b0};
          bitsLeft <= parLatched ? 4'd11 : 4'd10;
          baudCnt  <= '0;
          busy     <= 1'b1;
        end else if (busy) begin
          if (baudCnt == BAUD_LAST) begin
            baudCnt  <= '0;
            shiftReg <= {1'b1, shiftReg[10:1]};
            bitsLeft <= bitsLeft - 4'd1;
            if (bitsLeft == 4'd1) busy <= 1'b0;
          end else begin
            baudCnt <= baudCnt + BAUD_W'(1);
          end
        end
      end
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    memRdEn |=> !memRdEn); // R11
  AST_STOP_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    charEnd |-> txBit); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.run && inFlight && addr != ADDR_MAX) |=> addr == $past(addr) + ADDR_W'(1)); // R3
  AST_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.run && charEnd && (haveCur || nextValid)) |=> busy && bitsLeft == (parLatched ? 4'd11 : 4'd10)); // R6
endmodule

// File: rtl/seq_read_stream.sv
module seq_read_stream
  import srs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int WORD_W   = 16,
  parameter int BIT_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csIn,
  input  logic              cmdStart,
  input  logic              byteValid,
  input  logic [7:0]        byteIn,
  input  logic              readAllowed,
  input  logic              parityEn,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [WORD_W-1:0] memRdData,
  output logic              txData,
  output logic              txOe
);
  srs_ctl_t ctl;
  logic     streamDone;

  srs_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .csIn(csIn), .cmdStart(cmdStart),
    .byteValid(byteValid), .readAllowed(readAllowed),
    .streamDone(streamDone), .ctl(ctl), .txOe(txOe)
  );

  srs_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BIT_CLKS(BIT_CLKS)) i_datapath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .byteIn(byteIn), .parityEn(parityEn),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .txBit(txData), .streamDone(streamDone)
  );

  AST_READ_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
    memRdEn |-> txOe); // R8
  AST_CS_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !csIn |-> (!txOe && !memRdEn)); // R8
endmodule

// File: tb/test_seq_read_stream.sv
`timescale 1ns/1ps
module test_seq_read_stream;
  localparam int ADDR_W = 8;
  localparam int WORD_W = 16;
  localparam int BIT_CLKS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csIn = 1'b0, cmdStart = 1'b0, byteValid = 1'b0, readAllowed = 1'b1, parityEn = 1'b0;
  logic [7:0] byteIn = '0;
  logic memRdEn, txData, txOe;
  logic [ADDR_W-1:0] memAddr;
  logic [WORD_W-1:0] memRdData = '0;

  int cyc = 0, checks = 0, failures = 0, rdCount = 0, oeCount = 0;
  bit done = 0;

  seq_read_stream #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BIT_CLKS(BIT_CLKS)) i_seq_read_stream (
    .clk(clk), .rst_n(rst_n), .csIn(csIn), .cmdStart(cmdStart), .byteValid(byteValid),
    .byteIn(byteIn), .readAllowed(readAllowed), .parityEn(parityEn), .memRdEn(memRdEn),
    .memAddr(memAddr), .memRdData(memRdData), .txData(txData), .txOe(txOe)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] memFn(input logic [7:0] a);
    return {a ^ 8'hA5, a + 8'h3C};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memRdEn) begin
      memRdData <= memFn(memAddr);
      rdCount <= rdCount + 1;
    end
    if (txOe) oeCount <= oeCount + 1;
    if (cyc == 150000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk) cmdStart = 1'b1;
    @(negedge clk) begin cmdStart = 1'b0; byteValid = 1'b1; byteIn = hi; end
    @(negedge clk) byteValid = 1'b0;
    @(negedge clk) begin byteValid = 1'b1; byteIn = lo; end
    @(negedge clk) byteValid = 1'b0;
  endtask

  task automatic csCycle();
    @(negedge clk) csIn = 1'b0;
    repeat (3) @(negedge clk);
    csIn = 1'b1;
    @(negedge clk);
  endtask

  task automatic getChar(input int nb, output logic [7:0] d, output logic p,
                         output bit stopOk, output int at, output bit got);
    got = 0; d = '0; p = 1'b0; stopOk = 1; at = 0;
    for (int w = 0; w < 400; w++) begin
      @(negedge clk);
      if (txOe && !txData) begin got = 1; break; end
    end
    if (!got) return;
    at = cyc;
    for (int k = 1; k < nb; k++) begin
      logic b;
      repeat (BIT_CLKS) @(negedge clk);
      b = txData;
      if (k <= 8) d[k-1] = b;
      else if (k == nb - 1) stopOk = b && txOe;
      else p = b;
    end
  endtask

  task automatic expectWords(input logic [7:0] a0, input int nWords, input bit par,
                             input string req, input bit flipParity);
    int prevAt = -1;
    int nb = par ? 11 : 10;
    for (int w = 0; w < nWords; w++) begin
      logic [15:0] word = memFn(a0 + 8'(w));
      for (int c = 0; c < 2; c++) begin
        logic [7:0] d, expd;
        logic p;
        bit stopOk, got;
        int at;
        expd = (c == 0) ? word[15:8] : word[7:0];
        getChar(nb, d, p, stopOk, at, got);
        check(got, req, "character missing", 0, 1);
        if (!got) return;
        check(d == expd, req, "data byte (R2/R3 order, R4 LSB first)", d, expd);
        check(stopOk, "R4", "stop bit", 0, 1);
        if (par) check(p == ^d, "R5", "even parity bit", p, ^d);
        if (prevAt >= 0) check(at - prevAt == nb * BIT_CLKS, "R6", "start-to-start spacing", at - prevAt, nb * BIT_CLKS);
        prevAt = at;
        if (flipParity && w == 0 && c == 0) parityEn = ~parityEn;
      end
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(txOe == 1'b0, "R1", "txOe after reset", txOe, 0);
    check(txData == 1'b1, "R1", "txData after reset", txData, 1);
    check(memRdEn == 1'b0, "R1", "memRdEn after reset", memRdEn, 0);
  endtask

  task automatic testBasicAndCsDrop();
    int r0;
    parityEn = 1'b0;
    csIn = 1'b1;
    sendCmd(8'h00, 8'h10);
    expectWords(8'h10, 2, 0, "R2", 0);
    repeat (BIT_CLKS * 3) @(negedge clk);
    csIn = 1'b0;
    #1 check(txOe == 1'b0, "R8", "txOe in cycle chip select drops", txOe, 0);
    r0 = rdCount;
    repeat (60) @(negedge clk);
    check(rdCount == r0, "R8", "reads after chip select low", rdCount, r0);
    csIn = 1'b1;
    r0 = oeCount;
    repeat (40) @(negedge clk);
    check(oeCount == r0, "R8", "stream resumed without command", oeCount, r0);
  endtask

  task automatic testParity();
    csCycle();
    parityEn = 1'b1;
    sendCmd(8'hA3, 8'h7E);
    expectWords(8'h7E, 3, 1, "R5", 1);
    parityEn = 1'b0;
  endtask

  task automatic testTopOfMemory();
    int r0, o0;
    csCycle();
    r0 = rdCount;
    sendCmd(8'h00, 8'hFD);
    expectWords(8'hFD, 3, 0, "R3", 0);
    repeat (BIT_CLKS + 3) @(negedge clk);
    check(txOe == 1'b0, "R7", "txOe after top address", txOe, 0);
    check(rdCount - r0 == 3, "R11", "reads for three words", rdCount - r0, 3);
    o0 = oeCount;
    sendCmd(8'h00, 8'h20);
    repeat (60) @(negedge clk);
    check(oeCount == o0, "R7", "command accepted before chip select low", oeCount, o0);
    check(rdCount - r0 == 3, "R7", "reads after end of memory", rdCount - r0, 3);
  endtask

  task automatic testProtected();
    int r0, o0;
    csCycle();
    readAllowed = 1'b0;
    r0 = rdCount; o0 = oeCount;
    sendCmd(8'h00, 8'h40);
    repeat (60) @(negedge clk);
    check(rdCount == r0, "R9", "reads when denied", rdCount, r0);
    check(oeCount == o0, "R9", "txOe when denied", oeCount, o0);
    readAllowed = 1'b1;
    sendCmd(8'h00, 8'h40);
    repeat (60) @(negedge clk);
    check(oeCount == o0, "R9", "command after denial without chip select low", oeCount, o0);
  endtask

  task automatic testIgnored();
    int o0;
    csCycle();
    o0 = oeCount;
    @(negedge clk) begin byteValid = 1'b1; byteIn = 8'h55; end
    @(negedge clk) byteValid = 1'b0;
    @(negedge clk) begin byteValid = 1'b1; byteIn = 8'h66; end
    @(negedge clk) byteValid = 1'b0;
    repeat (30) @(negedge clk);
    check(oeCount == o0, "R10", "bytes without command", oeCount, o0);
    @(negedge clk) begin csIn = 1'b0; cmdStart = 1'b1; end
    @(negedge clk) begin csIn = 1'b1; cmdStart = 1'b0; end
    @(negedge clk) begin byteValid = 1'b1; byteIn = 8'h00; end
    @(negedge clk) byteValid = 1'b0;
    @(negedge clk) begin byteValid = 1'b1; byteIn = 8'h44; end
    @(negedge clk) byteValid = 1'b0;
    repeat (30) @(negedge clk);
    check(oeCount == o0, "R10", "command seen with chip select low", oeCount, o0);
    sendCmd(8'h00, 8'h30);
    expectWords(8'h30, 1, 0, "R10", 0);
    @(negedge clk) csIn = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testBasicAndCsDrop();
    testParity();
    testTopOfMemory();
    testProtected();
    testIgnored();
    repeat (10) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule